// File: doc/BRIEF.md
# Debug Halt Timer Gating Controller

This block holds three system timers and decides, cycle by cycle, whether each may advance while cores are stopped for debug. Each core drives a halted-for-debug flag that is high for as long as the core is stopped, for whatever reason, and low once it runs again. A separate trigger line gives a second, software-routed way to request a pause. All of these inputs cross into the block's clock domain through a two-flop synchronizer before any decision uses them.

The free-running system counter and the watchdog each have a software-written policy. The policy is a two-bit mode and a per-core participation mask. The mode selects one of four behaviours: keep running; pause when any selected core is halted; pause only when every selected core is halted; or pause on the trigger line. The trace timestamp counter has no policy and runs through every halt. The watchdog counts down from a reload value and emits a single-cycle expiry pulse when it reaches zero. A write to its service register restarts it. It cannot expire while it is paused. Software reads back the counter values, the policies and a live paused flag for each counter.

Top module: `dbg_timer_gate`

## Requirements
- R1: The halt flags and the trigger line act through two synchronizing flops. A change driven just after a clock edge shows in the paused status after the second following edge and not after the first.
- R2: Mode value 0 (bits [1:0] of a policy register) never pauses its counter, whatever the halt flags and trigger are.
- R3: Mode value 1 pauses the counter while at least one core whose mask bit is set is halted. Halted cores outside the mask have no effect. The mask sits at bits [NCORES+1:2] of the policy register.
- R4: Mode value 2 pauses the counter only while every core whose mask bit is set is halted.
- R5: In modes 1 and 2, an all-zero mask never pauses the counter.
- R6: Mode value 3 pauses the counter while the synchronized trigger line is high, and ignores the core flags.
- R7: While the system counter is paused, its value does not change. Once the condition clears, it counts again.
- R8: The timestamp counter advances by one on every clock cycle after reset, including cycles in which any core is halted.
- R9: While running, the watchdog decrements once per cycle. In the cycle after it holds zero, it raises the expiry output for exactly one cycle and reloads. From a service write it takes reload+1 running cycles to expire.
- R10: A write to the service register (address 3) loads the watchdog with the reload value (address 2) at that clock edge.
- R11: While the watchdog is paused, its value holds and the expiry output stays low.
- R12: Reset sets the system counter and timestamp to zero and the watchdog to WD_INIT. The system policy resets to mode 2 with all cores selected. The watchdog policy resets to mode 1 with all cores selected.
- R13: The status register (address 7) shows the system counter paused in bit 0, a constant zero for the timestamp in bit 1, and the watchdog paused in bit 2. cnt_en_o carries the matching run enables in bits 0, 1 and 2. Address 0 is the system policy, 1 the watchdog policy, 4 the system count, 5 the timestamp and 6 the watchdog count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_halt_i | input | NCORES | Per-core halted-for-debug flags, asynchronous |
| ext_trig_i | input | 1 | External pause trigger, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |
| cnt_en_o | output | 3 | Run enables: system counter, timestamp, watchdog |
| wdog_expire_o | output | 1 | One-cycle watchdog expiry pulse |

## Verification
The hardest situation to reach from the ports is a watchdog that reaches zero at the moment a pause takes hold, so that a missed gate would let it expire while halted. The bench gets there by pausing the watchdog through its own policy, servicing it while paused, and running long past its reload length while watching the expiry line. It also measures the exact cycle of expiry from a service write, so that an off-by-one in the reload or the pulse timing shows at the ports. The policy decode is covered by a table of mode, mask, flag and trigger combinations. The table includes halted cores outside the mask and empty masks.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    typedef enum logic [1:0] {
        GM_FREE = 2'b00,
        GM_ANY  = 2'b01,
        GM_ALL  = 2'b10,
        GM_EXT  = 2'b11
    } gate_mode_e;

    typedef enum logic [2:0] {
        A_SYS_POL = 3'd0,
        A_WD_POL  = 3'd1,
        A_WD_RLD  = 3'd2,
        A_WD_SVC  = 3'd3,
        A_SYS_CNT = 3'd4,
        A_TS_CNT  = 3'd5,
        A_WD_CNT  = 3'd6,
        A_STATUS  = 3'd7
    } reg_addr_e;

    localparam int MAX_CORES = 32;

    typedef struct packed {
        gate_mode_e             mode;
        logic [MAX_CORES-1:0]   mask;
    } policy_t;

    function automatic logic pause_needed(policy_t pol, logic [MAX_CORES-1:0] halted, logic ext);
        logic hit;
        unique case (pol.mode)
            GM_ANY:  hit = |(pol.mask & halted);
            GM_ALL:  hit = (pol.mask != '0) && ((pol.mask & ~halted) == '0);
            GM_EXT:  hit = ext;
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/dtg_sync.sv
module dtg_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/dtg_policy.sv
module dtg_policy
    import dtg_pkg::*;
#(
    parameter int NCORES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  policy_t           pol_i,
    input  logic [NCORES-1:0] halted_i,
    input  logic              ext_i,
    output logic              run_o
);
    assign run_o = !pause_needed(pol_i, MAX_CORES'(halted_i), ext_i);

    // R2: free mode always runs
    a_r2_free_runs: assert property (@(posedge clk) disable iff (rst)
        (pol_i.mode == GM_FREE) |-> run_o);

    // R5: empty mask in core modes always runs
    a_r5_empty_mask_runs: assert property (@(posedge clk) disable iff (rst)
        ((pol_i.mode == GM_ANY || pol_i.mode == GM_ALL) && pol_i.mask == '0) |-> run_o);
endmodule

// File: rtl/dtg_wdog.sv
module dtg_wdog #(
    parameter int          W    = 16,
    parameter logic [W-1:0] INIT = W'(1000)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic         svc_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] cnt_o,
    output logic         expire_o
);
    logic [W-1:0] cnt_q;
    logic         exp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= INIT;
            exp_q <= 1'b0;
        end else begin
            exp_q <= run_i && !svc_i && (cnt_q == '0);
            if (svc_i) begin
                cnt_q <= reload_i;
            end else if (run_i) begin
                cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign expire_o = exp_q;

    // R11: a paused watchdog holds its count
    a_r11_hold_when_paused: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !svc_i) |=> $stable(cnt_q));

    // R11: no expiry out of a paused cycle
    a_r11_no_expire_paused: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !expire_o);
endmodule

// File: rtl/dbg_timer_gate.sv
module dbg_timer_gate
    import dtg_pkg::*;
#(
    parameter int NCORES  = 4,
    parameter int CW      = 32,
    parameter int WDW     = 16,
    parameter int WD_INIT = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCORES-1:0] core_halt_i,
    input  logic              ext_trig_i,
    input  logic              reg_wr_i,
    input  logic [2:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic [2:0]        cnt_en_o,
    output logic              wdog_expire_o
);
    localparam int                   NGATED   = 2;
    localparam int                   SYNC_W   = NCORES + 1;
    localparam logic [MAX_CORES-1:0] MASK_ALL = MAX_CORES'((64'd1 << NCORES) - 64'd1);
    localparam policy_t              SYS_RST  = '{mode: GM_ALL, mask: MASK_ALL};
    localparam policy_t              WD_RST   = '{mode: GM_ANY, mask: MASK_ALL};

    logic [SYNC_W-1:0] sync_q;
    logic [NGATED-1:0] run;
    policy_t           pol_q [NGATED];
    logic [WDW-1:0]    wd_reload_q;
    logic [WDW-1:0]    wd_cnt;
    logic [CW-1:0]     sys_cnt_q;
    logic [CW-1:0]     ts_cnt_q;
    logic              wd_svc;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata_i;

    dtg_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({ext_trig_i, core_halt_i}),
        .q_o (sync_q)
    );

    for (genvar g = 0; g < NGATED; g++) begin : g_gate
        dtg_policy #(.NCORES(NCORES)) u_pol (
            .clk      (clk),
            .rst      (rst),
            .pol_i    (pol_q[g]),
            .halted_i (sync_q[NCORES-1:0]),
            .ext_i    (sync_q[NCORES]),
            .run_o    (run[g])
        );
    end

    function automatic policy_t decode_policy(logic [31:0] wd);
        policy_t p;
        p.mode = gate_mode_e'(wd[1:0]);
        p.mask = MAX_CORES'(wd[NCORES+1:2]);
        return p;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q[0]    <= SYS_RST;
            pol_q[1]    <= WD_RST;
            wd_reload_q <= WDW'(WD_INIT);
        end else if (reg_wr_i) begin
            case (reg_addr_e'(reg_addr_i))
                A_SYS_POL: pol_q[0]    <= decode_policy(reg_wdata_i);
                A_WD_POL:  pol_q[1]    <= decode_policy(reg_wdata_i);
                A_WD_RLD:  wd_reload_q <= reg_wdata_i[WDW-1:0];
                default: ;
            endcase
        end
    end

    assign wd_svc = reg_wr_i && (reg_addr_e'(reg_addr_i) == A_WD_SVC);

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_cnt_q <= '0;
            ts_cnt_q  <= '0;
        end else begin
            ts_cnt_q <= ts_cnt_q + 1'b1;
            if (run[0]) sys_cnt_q <= sys_cnt_q + 1'b1;
        end
    end

    dtg_wdog #(.W(WDW), .INIT(WDW'(WD_INIT))) u_wdog (
        .clk      (clk),
        .rst      (rst),
        .run_i    (run[1]),
        .svc_i    (wd_svc),
        .reload_i (wd_reload_q),
        .cnt_o    (wd_cnt),
        .expire_o (wdog_expire_o)
    );

    always_comb begin
        case (reg_addr_e'(reg_addr_i))
            A_SYS_POL: reg_rdata_o = 32'({pol_q[0].mask[NCORES-1:0], pol_q[0].mode});
            A_WD_POL:  reg_rdata_o = 32'({pol_q[1].mask[NCORES-1:0], pol_q[1].mode});
            A_WD_RLD:  reg_rdata_o = 32'(wd_reload_q);
            A_SYS_CNT: reg_rdata_o = 32'(sys_cnt_q);
            A_TS_CNT:  reg_rdata_o = 32'(ts_cnt_q);
            A_WD_CNT:  reg_rdata_o = 32'(wd_cnt);
            A_STATUS:  reg_rdata_o = {29'd0, !run[1], 1'b0, !run[0]};
            default:   reg_rdata_o = '0;
        endcase
    end

    assign cnt_en_o = {run[1], 1'b1, run[0]};

    // R7: frozen system counter holds its value
    a_r7_sys_frozen: assert property (@(posedge clk) disable iff (rst)
        !run[0] |=> $stable(sys_cnt_q));

    // R8: timestamp advances every cycle
    a_r8_ts_free: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ts_cnt_q == $past(ts_cnt_q) + CW'(1));
endmodule

// File: tb/dbg_timer_gate_tb_top.sv
`timescale 1ns/1ps
module dbg_timer_gate_tb_top;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC-1:0] halt = '0;
    logic          ext = 1'b0;
    logic          wr = 1'b0;
    logic [2:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [2:0]    en;
    logic          expire;

    int n_vec = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    dbg_timer_gate #(.NCORES(NC), .CW(32), .WDW(16), .WD_INIT(1000)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .core_halt_i   (halt),
        .ext_trig_i    (ext),
        .reg_wr_i      (wr),
        .reg_addr_i    (addr),
        .reg_wdata_i   (wdata),
        .reg_rdata_o   (rdata),
        .cnt_en_o      (en),
        .wdog_expire_o (expire)
    );

    // {mode[1:0], mask[3:0], halt[3:0], ext, expected_paused}
    localparam logic [11:0] VEC [12] = '{
        {2'b00, 4'b1111, 4'b1111, 1'b1, 1'b0},  // R2
        {2'b01, 4'b1111, 4'b0000, 1'b0, 1'b0},  // R3
        {2'b01, 4'b1111, 4'b0100, 1'b0, 1'b1},  // R3
        {2'b01, 4'b0011, 4'b0100, 1'b0, 1'b0},  // R3 outside mask
        {2'b10, 4'b1111, 4'b0111, 1'b0, 1'b0},  // R4
        {2'b10, 4'b1111, 4'b1111, 1'b0, 1'b1},  // R4
        {2'b10, 4'b0101, 4'b0101, 1'b0, 1'b1},  // R4
        {2'b10, 4'b0101, 4'b0100, 1'b0, 1'b0},  // R4
        {2'b10, 4'b0000, 4'b1111, 1'b0, 1'b0},  // R5
        {2'b01, 4'b0000, 4'b1111, 1'b1, 1'b0},  // R5
        {2'b11, 4'b0000, 4'b0000, 1'b1, 1'b1},  // R6
        {2'b11, 4'b1111, 4'b1111, 1'b0, 1'b0}   // R6
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string tag_of(input logic [11:0] v);
        if (v[11:10] == 2'b00) return "R2";
        if (v[11:10] == 2'b11) return "R6";
        if (v[9:6] == 4'b0000) return "R5";
        if (v[11:10] == 2'b01) return "R3";
        return "R4";
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin : main
        logic [31:0] a, b, c;
        int first;
        bit seen;

        // R12: reset state, sampled while reset is held
        cycles(3);
        rd_reg(3'd0, a); check("R12 sys policy", a, 32'h3E);
        rd_reg(3'd1, a); check("R12 wdog policy", a, 32'h3D);
        rd_reg(3'd4, a); check("R12 sys count", a, 0);
        rd_reg(3'd5, a); check("R12 timestamp", a, 0);
        rd_reg(3'd6, a); check("R12 wdog count", a, 1000);
        @(negedge clk); rst = 1'b0;

        // R2..R6 policy table on the system counter
        for (int i = 0; i < 12; i++) begin
            wr_reg(3'd0, {26'd0, VEC[i][9:6], VEC[i][11:10]});
            halt = VEC[i][5:2];
            ext  = VEC[i][1];
            cycles(3);
            rd_reg(3'd7, a);
            check(tag_of(VEC[i]), {31'd0, a[0]}, {31'd0, VEC[i][0]});
            check("R13 enable", {31'd0, en[0]}, {31'd0, ~VEC[i][0]});
        end
        halt = '0; ext = 1'b0;

        // R1: two-flop latency
        wr_reg(3'd0, 32'h3D);
        cycles(3);
        halt = 4'b0001;
        cycles(1);
        rd_reg(3'd7, a); check("R1 not yet paused", {31'd0, a[0]}, 0);
        cycles(1);
        rd_reg(3'd7, a); check("R1 paused", {31'd0, a[0]}, 1);

        // R7: frozen value, then resumes
        cycles(2);
        rd_reg(3'd4, a);
        cycles(10);
        rd_reg(3'd4, b); check("R7 frozen", b, a);
        halt = '0;
        cycles(6);
        rd_reg(3'd4, c); check("R7 resumes", {31'd0, c != b}, 1);

        // R8: timestamp runs through halts
        halt = 4'b1111; ext = 1'b1;
        cycles(3);
        rd_reg(3'd5, a);
        cycles(10);
        rd_reg(3'd5, b); check("R8 timestamp step", b - a, 10);

        // R13: watchdog paused flag and constant zero timestamp bit
        rd_reg(3'd7, a); check("R13 status", {29'd0, a[2:0]}, 32'b101);
        halt = '0; ext = 1'b0;

        // R9 / R10: watchdog running
        wr_reg(3'd1, 32'h0);
        wr_reg(3'd2, 32'd5);
        wr_reg(3'd3, 32'd0);
        rd_reg(3'd6, a); check("R10 service loads reload", a, 5);
        first = 0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (expire && first == 0) begin
                first = i;
                rd_reg(3'd6, b); check("R9 reload after expiry", b, 5);
            end
            if (i == 7) check("R9 single-cycle pulse", {31'd0, expire}, 0);
        end
        check("R9 expiry cycle", first, 6);

        // R11: paused watchdog never expires
        wr_reg(3'd1, 32'h05);
        halt = 4'b0001;
        cycles(3);
        wr_reg(3'd3, 32'd0);
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (expire) seen = 1'b1;
        end
        check("R11 no expiry while paused", {31'd0, seen}, 0);
        rd_reg(3'd6, a); check("R11 count held", a, 5);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule